// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Controller with Battery Check

This block sits between an address decoder and a battery-backed memory. It passes an active-low chip-enable from `ce_in_n` to `ce_out_n` only while the supervised system is out of reset. While reset is active, the path is closed and the output is held high. If reset arrives while an access is already driving the memory, that access is allowed to finish. The output stays low until the input returns high or until a bounded number of cycles has passed, whichever comes first. After that the path stays closed until reset is released.

The block also records the state of the backup battery. During the timeout window that follows a reset, a battery-low flag is watched. If the flag was seen, the second chip-enable pulse after the window is swallowed whole. Software can write one pattern with the first pulse and a different pattern with the second, then read the location back to learn the battery state.

All pins are plain level signals sampled on the rising clock edge. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. The path state changes at the clock edge at which `sys_rst` is sampled. While the path is open, the output follows the input combinationally.

Top module: `ceg_ce_gate`

## Requirements
- R1: While the path is open and no pulse is being suppressed, `ce_out_n` equals `ce_in_n`.
- R2: While `sys_rst` is high and no hold is in progress, `ce_out_n` is 1 whatever the value of `ce_in_n`.
- R3: If `sys_rst` is first sampled high while the output is passing a low, the output stays low. It ends the hold at the first edge that samples `ce_in_n` high. Otherwise it stays low for exactly HOLD_CYC rising edges, counting the edge that first sampled reset, and is high after the next edge.
- R4: Once a hold ends, `ce_out_n` stays 1 for as long as `sys_rst` stays high, even if `ce_in_n` falls again.
- R5: After `rst_n` is released, the path is closed (`ce_out_n` = 1). It stays closed until the first edge at which `sys_rst` is sampled low.
- R6: `batt_low` only counts on edges at which `tmo_win` is 1. Outside the window it has no effect on which pulses pass.
- R7: The battery decision is taken at the edge where `tmo_win` is first sampled low after being high. It is cleared at the next edge at which `sys_rst` is sampled rising. A reset with no window therefore lets every pulse pass.
- R8: With a low-battery decision in place, the second falling edge of `ce_in_n` seen while the path is open starts a pulse that is blocked. `ce_out_n` stays 1 for the whole low period of that pulse.
- R9: The pulse counter saturates. The first, third and every later pulse pass unchanged even when the battery decision is low.
- R10: If `ce_in_n` is already low when the path opens, that low passes through and is not counted as a pulse. The first falling edge after opening is pulse one.
- R11: With a good-battery decision, every pulse passes, including the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of the block's own state |
| sys_rst | input | 1 | Supervised system reset, 1 = reset active |
| tmo_win | input | 1 | 1 while the post-reset timeout window runs |
| batt_low | input | 1 | 1 when the backup battery is below its limit |
| ce_in_n | input | 1 | Active-low chip-enable from the decoder |
| ce_out_n | output | 1 | Gated active-low chip-enable to the memory |

## Verification
Two situations are hard to reach from the pins.

The first is a reset that lands in the middle of a passing access. The bench first lowers the chip-enable with the path open. It then raises reset with the input still low and counts edges until the hold runs out. It repeats this with the input released part-way through the hold.

The second is the swallowed second pulse. It needs a full sequence: reset, a window with the flag raised, window end, and then counted falling edges. The bench also opens the path with the input already low, to show that this held low does not shift which pulse is swallowed.

// File: rtl/ceg_pkg.sv
package ceg_pkg;
  typedef enum logic [1:0] {
    PATH_BLOCK = 2'd0,
    PATH_HOLD  = 2'd1,
    PATH_OPEN  = 2'd2
  } path_mode_e;
endpackage

// File: rtl/ceg_path_ctl.sv
module ceg_path_ctl import ceg_pkg::*; #(
  parameter int HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       ce_in_n,
  input  logic       access_live,
  output path_mode_e mode
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= PATH_BLOCK;
      hold_cnt <= '0;
    end else if (!sys_rst) begin
      mode     <= PATH_OPEN;
      hold_cnt <= '0;
    end else begin
      case (mode)
        PATH_OPEN: begin
          if (access_live && !ce_in_n) begin
            mode     <= PATH_HOLD;
            hold_cnt <= HOLD_W'(HOLD_CYC - 1);
          end else begin
            mode <= PATH_BLOCK;
          end
        end
        PATH_HOLD: begin
          if (ce_in_n || hold_cnt == '0) mode <= PATH_BLOCK;
          else hold_cnt <= hold_cnt - 1'b1;
        end
        default: mode <= PATH_BLOCK;
      endcase
    end
  end

  // R4: a closed path never reopens while reset stays active
  a_r4_stay_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PATH_BLOCK && sys_rst) |=> (mode == PATH_BLOCK));

  // R3: a hold is only entered from an open path carrying a live access
  a_r3_hold_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode == PATH_HOLD) |-> ($past(mode) == PATH_OPEN && !$past(ce_in_n)));

  // R3: the hold counter only moves down, so the hold is bounded
  a_r3_hold_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PATH_HOLD && sys_rst) |=>
      (mode != PATH_HOLD || hold_cnt < $past(hold_cnt)));
endmodule

// File: rtl/ceg_batt_latch.sv
module ceg_batt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic tmo_win,
  input  logic batt_low,
  output logic batt_bad
);
  logic sys_q;
  logic win_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q    <= 1'b0;
      win_q    <= 1'b0;
      seen_q   <= 1'b0;
      batt_bad <= 1'b0;
    end else begin
      sys_q <= sys_rst;
      win_q <= tmo_win;
      if (sys_rst && !sys_q) begin
        seen_q   <= 1'b0;
        batt_bad <= 1'b0;
      end else if (win_q && !tmo_win) begin
        batt_bad <= seen_q;
        seen_q   <= 1'b0;
      end else if (tmo_win && batt_low) begin
        seen_q <= 1'b1;
      end
    end
  end

  // R7: a fresh reset assertion wipes the battery decision
  a_r7_clear_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |=> !batt_bad);

  // R6: the flag cannot be captured outside the window
  a_r6_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tmo_win |=> !$rose(seen_q));
endmodule

// File: rtl/ceg_pulse_gate.sv
module ceg_pulse_gate #(
  parameter int SKIP_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic path_open,
  input  logic batt_bad,
  input  logic ce_in_n,
  output logic suppress
);
  localparam int CNT_MAX = SKIP_PULSE + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             ce_q;
  logic             sup_q;
  logic [CNT_W-1:0] cnt;
  logic             fall_now;
  logic             hit_skip;

  assign fall_now = path_open && ce_q && !ce_in_n;
  assign hit_skip = batt_bad && (cnt == CNT_W'(SKIP_PULSE - 1));
  assign suppress = fall_now ? hit_skip : sup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b1;
      sup_q <= 1'b0;
      cnt   <= '0;
    end else begin
      ce_q <= ce_in_n;
      if (!path_open) begin
        sup_q <= 1'b0;
        cnt   <= '0;
      end else if (fall_now) begin
        sup_q <= hit_skip;
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end else if (ce_in_n) begin
        sup_q <= 1'b0;
      end
    end
  end

  // R8: a block only ever starts on the selected pulse
  a_r8_skip_index: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_q) |-> (cnt == CNT_W'(SKIP_PULSE)));

  // R8: a blocked pulse stays blocked while the input stays low
  a_r8_whole_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_q && !ce_in_n && path_open) |=> sup_q);

  // R9: the counter saturates instead of wrapping back to the skip index
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (path_open && cnt == CNT_W'(CNT_MAX)) |=> (cnt == CNT_W'(CNT_MAX)));
endmodule

// File: rtl/ceg_ce_gate.sv
module ceg_ce_gate import ceg_pkg::*; #(
  parameter int HOLD_CYC   = 16,
  parameter int SKIP_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic tmo_win,
  input  logic batt_low,
  input  logic ce_in_n,
  output logic ce_out_n
);
  path_mode_e mode;
  logic       batt_bad;
  logic       suppress;
  logic       access_live;

  assign access_live = (mode == PATH_OPEN) && !ce_out_n;

  ceg_path_ctl #(.HOLD_CYC(HOLD_CYC)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_rst    (sys_rst),
    .ce_in_n    (ce_in_n),
    .access_live(access_live),
    .mode       (mode)
  );

  ceg_batt_latch u_batt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_rst (sys_rst),
    .tmo_win (tmo_win),
    .batt_low(batt_low),
    .batt_bad(batt_bad)
  );

  ceg_pulse_gate #(.SKIP_PULSE(SKIP_PULSE)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .path_open(mode == PATH_OPEN),
    .batt_bad (batt_bad),
    .ce_in_n  (ce_in_n),
    .suppress (suppress)
  );

  always_comb begin
    case (mode)
      PATH_OPEN: ce_out_n = ce_in_n | suppress;
      PATH_HOLD: ce_out_n = ce_in_n;
      default:   ce_out_n = 1'b1;
    endcase
  end

  // R1: the memory never sees a low the decoder did not request
  a_r1_low_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_out_n |-> !ce_in_n);

  // R2: a closed path under reset keeps the output high on the next cycle
  a_r2_closed_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && mode == PATH_BLOCK) |=> ce_out_n);
endmodule

// File: tb/ceg_ce_gate_bench.sv
module ceg_ce_gate_bench;
  localparam int HOLD = 16;
  localparam int NVEC = 11;
  // bit order {sys_rst, tmo_win, batt_low, ce_in_n, expected ce_out_n}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_0_0_1_1,  // R5 closed after release of block reset
    5'b1_0_0_0_1,  // R2 input low ignored under reset
    5'b1_1_0_1_1,  // window, battery good
    5'b1_1_0_1_1,
    5'b0_0_0_1_1,  // release, decision good
    5'b0_0_0_0_0,  // R1 pulse one
    5'b0_0_0_1_1,
    5'b0_0_0_0_0,  // R11 pulse two passes
    5'b0_0_0_1_1,
    5'b0_0_1_0_0,  // R6 flag outside window, pulse three
    5'b0_0_0_1_1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_rst = 1'b1;
  logic tmo_win = 1'b0;
  logic batt_low = 1'b0;
  logic ce_in_n = 1'b1;
  logic ce_out_n;
  int   checks = 0;
  int   fails = 0;

  always #2 clk = ~clk;

  ceg_ce_gate #(.HOLD_CYC(HOLD), .SKIP_PULSE(2)) u_ceg_ce_gate (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .tmo_win(tmo_win),
    .batt_low(batt_low), .ce_in_n(ce_in_n), .ce_out_n(ce_out_n)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (ce_out_n !== exp) begin
      fails++;
      $display("FAIL %s: ce_out_n=%b expected=%b at %0t", req, ce_out_n, exp, $time);
    end
  endtask

  task automatic drive(input logic sr, input logic win, input logic bl, input logic ce);
    sys_rst = sr; tmo_win = win; batt_low = bl; ce_in_n = ce;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R5", 1'b1);
    rst_n = 1'b1;
    step();
    check("R5", 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      step();
      check("table R1 R2 R5 R6 R11", VEC[i][0]);
    end

    // R8 R9: battery low seen in the window
    drive(1, 0, 0, 1); step(); check("R2", 1'b1);
    drive(1, 1, 1, 1); step();
    drive(1, 1, 0, 1); step();
    drive(0, 0, 0, 1); step(); check("R1", 1'b1);
    ce_in_n = 0; step(); check("R9", 1'b0);
    ce_in_n = 1; step();
    ce_in_n = 0; step(); check("R8", 1'b1);
    step(); check("R8", 1'b1);
    step(); check("R8", 1'b1);
    ce_in_n = 1; step(); check("R8", 1'b1);
    ce_in_n = 0; step(); check("R9", 1'b0);
    ce_in_n = 1; step();
    ce_in_n = 0; step(); check("R9", 1'b0);
    ce_in_n = 1; step();

    // R7: reset without a window clears the decision
    drive(1, 0, 0, 1); step(); step();
    drive(0, 0, 0, 1); step();
    ce_in_n = 0; step(); check("R7", 1'b0);
    ce_in_n = 1; step();
    ce_in_n = 0; step(); check("R7", 1'b0);
    ce_in_n = 1; step();

    // R6: flag raised just before the window is ignored
    drive(1, 0, 1, 1); step(); step();
    drive(1, 1, 0, 1); step(); step();
    drive(0, 0, 0, 1); step();
    ce_in_n = 0; step(); check("R6", 1'b0);
    ce_in_n = 1; step();
    ce_in_n = 0; step(); check("R6", 1'b0);
    ce_in_n = 1; step();

    // R3 R4: reset during an access, hold runs to its limit
    ce_in_n = 0; step(); check("R1", 1'b0);
    sys_rst = 1;
    for (int k = 0; k < HOLD; k++) begin
      step(); check("R3", 1'b0);
    end
    step(); check("R3", 1'b1);
    ce_in_n = 1; step(); check("R4", 1'b1);
    ce_in_n = 0; step(); check("R4", 1'b1);
    step(); check("R4", 1'b1);

    // R10 R3 R4: open with input low, then hold cut short by input high
    sys_rst = 0; step(); check("R10", 1'b0);
    ce_in_n = 1; step();
    ce_in_n = 0; step(); check("R1", 1'b0);
    sys_rst = 1; step(); check("R3", 1'b0);
    step(); check("R3", 1'b0);
    ce_in_n = 1; step(); check("R3", 1'b1);
    ce_in_n = 0; step(); check("R4", 1'b1);

    // R10: held low at opening is not pulse one under a low battery
    drive(1, 1, 1, 0); step();
    drive(1, 1, 0, 0); step();
    drive(0, 0, 0, 0); step(); check("R10", 1'b0);
    ce_in_n = 1; step();
    ce_in_n = 0; step(); check("R10", 1'b0);
    ce_in_n = 1; step();
    ce_in_n = 0; step(); check("R10", 1'b1);
    ce_in_n = 1; step(); check("R10", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule